// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a memory-mapped watchdog built around a down-counter that steps once for each pulse on a clock-enable input. When the counter runs out the first time, it raises an interrupt and starts again from the programmed load value. If it runs out a second time while that interrupt is still pending, and the reset path is enabled, it drives a system reset. That reset stays asserted until the block itself is reset. Software keeps the system alive by clearing the interrupt, which also restarts the count. It can also do so by writing a new load value.

A key register guards every other register against stray writes. Writing the unlock key opens the register set. Writing any other value to the key register closes it again. While the set is closed, writes to every other register are dropped. Register reads are combinational from the address. Writes take effect on the clock edge at which the write strobe is high.

Top module: `wdg_top`

## Requirements
- R1: After the synchronous active-high `rst`, the following read values hold. Load (0x000) reads 0xFFFFFFFF, control (0x008) reads 0, raw status (0x010) reads 0 and the key register (0xC00) reads 1 (closed). `irq_o` and `sys_rst_o` are low.
- R2: Writing 0x1ACCE551 to 0xC00 opens the register set, and 0xC00 then reads 0. Writing any other value to 0xC00 closes it, and 0xC00 then reads 1. This register accepts writes whether the set is open or closed.
- R3: While the set is closed, writes to 0x000, 0x008 and 0x00C change no register, no counter value and no interrupt state.
- R4: An accepted write to 0x000 stores the data and at the same edge loads the counter (read at 0x004) with it. A written value of 0 is stored as 1.
- R5: The counter drops by one on each edge where `tick_en` is high and control bit 0 is set. It holds its value whenever either of these is low.
- R6: On a tick at which the counter is 0, the raw interrupt is set and the counter reloads from the load value. A full period is therefore load+1 ticks.
- R7: An expiry that occurs while the raw interrupt is already set, with control bit 1 set, raises `sys_rst_o`. It stays high until `rst`. An expiry with control bit 1 clear leaves `sys_rst_o` low.
- R8: An accepted write of any data to 0x00C clears the raw interrupt and reloads the counter from the load value. A clear or load write in the same cycle as an expiry wins, and no expiry occurs in that cycle.
- R9: Bit 0 of 0x010 is the raw interrupt, whatever the enable state. Bit 0 of 0x014 and `irq_o` are the raw interrupt ANDed with control bit 0.
- R10: Control (0x008) keeps its bit 0 (count and interrupt enable) and bit 1 (reset enable) and reads them back. All other bits read 0, and so do unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter step enable |
| bus_addr | input | ADDR_W (12) | Register byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` |
| irq_o | output | 1 | Masked interrupt |
| sys_rst_o | output | 1 | Sticky system reset request |

## Verification
The bound checker watches several properties on every cycle. It checks that a closed register set leaves the load and control registers alone. It checks that the stored load value is never zero and that the counter holds when counting is disabled or steps by exactly one when enabled. It also checks that a clear always drops the interrupt, that the system reset is sticky and that the reset only rises after a cycle with a pending interrupt and the reset enable set. Some behaviour only the bench's scenarios can show. This covers the exact expiry timing of load+1 ticks and the two-period path to reset. It also covers the key register's read values, the masked status and the masking of `irq_o`. The bench runs these in directed sequences and then in a long random mix of ticks, writes and resets, compared against a bench model.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned OFS_LOAD  = 32'h000;
    localparam int unsigned OFS_VALUE = 32'h004;
    localparam int unsigned OFS_CTRL  = 32'h008;
    localparam int unsigned OFS_CLR   = 32'h00C;
    localparam int unsigned OFS_RAW   = 32'h010;
    localparam int unsigned OFS_MIS   = 32'h014;
    localparam int unsigned OFS_KEY   = 32'hC00;

    localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

    typedef enum logic [2:0] {
        SEL_LOAD,
        SEL_VALUE,
        SEL_CTRL,
        SEL_CLR,
        SEL_RAW,
        SEL_MIS,
        SEL_KEY,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode(input int unsigned a);
        case (a)
            OFS_LOAD:  return SEL_LOAD;
            OFS_VALUE: return SEL_VALUE;
            OFS_CTRL:  return SEL_CTRL;
            OFS_CLR:   return SEL_CLR;
            OFS_RAW:   return SEL_RAW;
            OFS_MIS:   return SEL_MIS;
            OFS_KEY:   return SEL_KEY;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] load_o,
    output logic [DATA_W-1:0] load_next_o,
    output logic              en_o,
    output logic              rst_en_o,
    output logic              locked_o,
    output logic              reload_o,
    output logic              clear_o
);

    localparam logic [DATA_W-1:0] LOAD_RST = '1;
    localparam logic [DATA_W-1:0] LOAD_MIN = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] load;
        logic              en;
        logic              rst_en;
        logic              locked;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;
    logic     wr_ok;

    always_comb begin
        sel      = decode(32'(bus_addr));
        wr_ok    = bus_we && !r_q.locked;
        r_d      = r_q;
        reload_o = 1'b0;
        clear_o  = 1'b0;
        if (bus_we && sel == SEL_KEY) begin
            r_d.locked = (bus_wdata != DATA_W'(UNLOCK_KEY));
        end
        if (wr_ok) begin
            case (sel)
                SEL_LOAD: begin
                    r_d.load = (bus_wdata == '0) ? LOAD_MIN : bus_wdata;
                    reload_o = 1'b1;
                end
                SEL_CTRL: begin
                    r_d.en     = bus_wdata[0];
                    r_d.rst_en = bus_wdata[1];
                end
                SEL_CLR: begin
                    clear_o  = 1'b1;
                    reload_o = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.load   <= LOAD_RST;
            r_q.en     <= 1'b0;
            r_q.rst_en <= 1'b0;
            r_q.locked <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign load_o      = r_q.load;
    assign load_next_o = r_d.load;
    assign en_o        = r_q.en;
    assign rst_en_o    = r_q.rst_en;
    assign locked_o    = r_q.locked;

endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              en,
    input  logic              rst_en,
    input  logic              reload,
    input  logic              clear,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] cnt_o,
    output logic              irq_raw_o,
    output logic              sys_rst_o
);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              irq;
        logic              sysrst;
    } core_t;

    core_t c_d, c_q;
    logic  step;
    logic  expire;

    always_comb begin
        step   = en && tick_en && !reload;
        expire = step && (c_q.cnt == '0);
        c_d    = c_q;
        if (reload) begin
            c_d.cnt = reload_val;
            if (clear) begin
                c_d.irq = 1'b0;
            end
        end else if (expire) begin
            c_d.cnt = reload_val;
            c_d.irq = 1'b1;
            if (c_q.irq && rst_en) begin
                c_d.sysrst = 1'b1;
            end
        end else if (step) begin
            c_d.cnt = c_q.cnt - DATA_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.cnt    <= '1;
            c_q.irq    <= 1'b0;
            c_q.sysrst <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_o     = c_q.cnt;
    assign irq_raw_o = c_q.irq;
    assign sys_rst_o = c_q.sysrst;

endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);

    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] load_next;
    logic [DATA_W-1:0] cnt;
    logic              en;
    logic              rst_en;
    logic              locked;
    logic              reload;
    logic              clear;
    logic              irq_raw;
    logic              masked;

    wdg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk         (clk),
        .rst         (rst),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .load_o      (load_q),
        .load_next_o (load_next),
        .en_o        (en),
        .rst_en_o    (rst_en),
        .locked_o    (locked),
        .reload_o    (reload),
        .clear_o     (clear)
    );

    wdg_core #(.DATA_W(DATA_W)) core_i (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .en         (en),
        .rst_en     (rst_en),
        .reload     (reload),
        .clear      (clear),
        .reload_val (load_next),
        .cnt_o      (cnt),
        .irq_raw_o  (irq_raw),
        .sys_rst_o  (sys_rst_o)
    );

    assign masked = irq_raw & en;
    assign irq_o  = masked;

    always_comb begin
        bus_rdata = '0;
        case (decode(32'(bus_addr)))
            SEL_LOAD:  bus_rdata = load_q;
            SEL_VALUE: bus_rdata = cnt;
            SEL_CTRL:  bus_rdata = {{(DATA_W-2){1'b0}}, rst_en, en};
            SEL_RAW:   bus_rdata = {{(DATA_W-1){1'b0}}, irq_raw};
            SEL_MIS:   bus_rdata = {{(DATA_W-1){1'b0}}, masked};
            SEL_KEY:   bus_rdata = {{(DATA_W-1){1'b0}}, locked};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
    import wdg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] load_q,
    input logic [DATA_W-1:0] cnt,
    input logic              en,
    input logic              rst_en,
    input logic              locked,
    input logic              reload,
    input logic              clear,
    input logic              irq_raw,
    input logic              sys_rst_o
);

    logic other_wr;
    assign other_wr = bus_we && (decode(32'(bus_addr)) != SEL_KEY);

    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (locked && other_wr) |=> ($stable(load_q) && $stable(en) && $stable(rst_en))); // R3

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load_q != '0); // R4

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ((!en || !tick_en) && !reload) |=> $stable(cnt)); // R5

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (en && tick_en && !reload && cnt != '0) |=> (cnt == $past(cnt) - DATA_W'(1))); // R5

    AST_RESET_STICKY: assert property (@(posedge clk) disable iff (rst)
        sys_rst_o |=> sys_rst_o); // R7

    AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_o) |-> ($past(irq_raw) && $past(rst_en))); // R7

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        clear |=> !irq_raw); // R8

endmodule

bind wdg_top wdg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .load_q    (load_q),
    .cnt       (cnt),
    .en        (en),
    .rst_en    (rst_en),
    .locked    (locked),
    .reload    (reload),
    .clear     (clear),
    .irq_raw   (irq_raw),
    .sys_rst_o (sys_rst_o)
);

// File: tb/wdg_top_tb_top.sv
module wdg_top_tb_top;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] A_LOAD  = 12'h000;
    localparam logic [ADDR_W-1:0] A_VALUE = 12'h004;
    localparam logic [ADDR_W-1:0] A_CTRL  = 12'h008;
    localparam logic [ADDR_W-1:0] A_CLR   = 12'h00C;
    localparam logic [ADDR_W-1:0] A_RAW   = 12'h010;
    localparam logic [ADDR_W-1:0] A_MIS   = 12'h014;
    localparam logic [ADDR_W-1:0] A_KEY   = 12'hC00;
    localparam logic [31:0]       KEY     = 32'h1ACCE551;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_o;
    logic              sys_rst_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model of the register state
    logic [31:0] m_load, m_cnt;
    logic [1:0]  m_ctrl;
    logic        m_lock, m_irq, m_rst;

    always #4 clk = ~clk;

    wdg_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .sys_rst_o (sys_rst_o)
    );

    function automatic logic [31:0] clamp_load(input logic [31:0] v);
        return (v == 0) ? 32'd1 : v;
    endfunction

    task automatic model_edge(input logic r, input logic we, input logic [11:0] a,
                              input logic [31:0] d, input logic t);
        logic [1:0] old_ctrl;
        logic       reloaded;
        old_ctrl = m_ctrl;
        reloaded = 0;
        if (r) begin
            m_load = 32'hFFFFFFFF; m_cnt = 32'hFFFFFFFF; m_ctrl = 0;
            m_lock = 1; m_irq = 0; m_rst = 0;
            return;
        end
        if (we) begin
            if (a == A_KEY) m_lock = (d != KEY);
            else if (!m_lock) begin
                if (a == A_LOAD) begin m_load = clamp_load(d); m_cnt = m_load; reloaded = 1; end
                else if (a == A_CTRL) m_ctrl = d[1:0];
                else if (a == A_CLR) begin m_irq = 0; m_cnt = m_load; reloaded = 1; end
            end
        end
        if (!reloaded && t && old_ctrl[0]) begin
            if (m_cnt == 0) begin
                if (m_irq && old_ctrl[1]) m_rst = 1;
                m_irq = 1;
                m_cnt = m_load;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
    endtask

    // one clock cycle; entered and left just after a falling edge
    task automatic cyc(input logic r, input logic we, input logic [11:0] a,
                       input logic [31:0] d, input logic t);
        rst = r; bus_we = we; bus_addr = a; bus_wdata = d; tick_en = t;
        @(posedge clk);
        model_edge(r, we, a, d, t);
        @(negedge clk);
        rst = 0; bus_we = 0; tick_en = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(1'b0, 1'b1, a, d, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 12'h0, 32'h0, 1'b1);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic peek(input string req, input logic [11:0] a, input logic [31:0] exp);
        bus_we = 0;
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic check_model();
        peek("R5 R6 value", A_VALUE, m_cnt);
        peek("R9 raw", A_RAW, {31'b0, m_irq});
        peek("R9 masked", A_MIS, {31'b0, m_irq & m_ctrl[0]});
        peek("R2 key", A_KEY, {31'b0, m_lock});
        peek("R10 ctrl", A_CTRL, {30'b0, m_ctrl});
        check("R9 irq_o", {31'b0, irq_o}, {31'b0, m_irq & m_ctrl[0]});
        check("R7 sys_rst_o", {31'b0, sys_rst_o}, {31'b0, m_rst});
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        cyc(1'b1, 1'b0, 12'h0, 32'h0, 1'b0);
        cyc(1'b1, 1'b0, 12'h0, 32'h0, 1'b0);

        // R1 reset state
        peek("R1 load", A_LOAD, 32'hFFFFFFFF);
        peek("R1 ctrl", A_CTRL, 32'h0);
        peek("R1 raw", A_RAW, 32'h0);
        peek("R1 key", A_KEY, 32'h1);
        check("R1 sys_rst_o", {31'b0, sys_rst_o}, 32'h0);
        check("R1 irq_o", {31'b0, irq_o}, 32'h0);

        // R3 writes while closed are dropped
        wr(A_LOAD, 32'd5);
        wr(A_CTRL, 32'd3);
        peek("R3 load kept", A_LOAD, 32'hFFFFFFFF);
        peek("R3 ctrl kept", A_CTRL, 32'h0);

        // R2 open the set
        wr(A_KEY, KEY);
        peek("R2 open", A_KEY, 32'h0);

        // R4 load write and zero clamp
        wr(A_LOAD, 32'd3);
        peek("R4 load", A_LOAD, 32'd3);
        peek("R4 value", A_VALUE, 32'd3);
        wr(A_LOAD, 32'd0);
        peek("R4 zero clamp", A_LOAD, 32'd1);
        wr(A_LOAD, 32'd3);

        // R5 halted while disabled
        ticks(5);
        peek("R5 halted", A_VALUE, 32'd3);

        // R10 control readback
        wr(A_CTRL, 32'hFFFF_FFFF);
        peek("R10 ctrl bits", A_CTRL, 32'd3);
        peek("R10 unmapped", 12'h100, 32'h0);

        // R6 first expiry after load+1 ticks
        ticks(3);
        peek("R5 counted", A_VALUE, 32'd0);
        check("R6 no irq yet", {31'b0, irq_o}, 32'h0);
        ticks(1);
        peek("R6 raw set", A_RAW, 32'h1);
        peek("R6 reloaded", A_VALUE, 32'd3);
        peek("R9 masked", A_MIS, 32'h1);
        check("R9 irq_o", {31'b0, irq_o}, 32'h1);

        // R8 clear
        ticks(2);
        wr(A_CLR, 32'h0);
        peek("R8 cleared", A_RAW, 32'h0);
        peek("R8 reload", A_VALUE, 32'd3);

        // R7 second expiry with reset enabled
        ticks(4);
        check("R7 not yet", {31'b0, sys_rst_o}, 32'h0);
        ticks(4);
        check("R7 reset raised", {31'b0, sys_rst_o}, 32'h1);
        wr(A_CLR, 32'h0);
        ticks(3);
        check("R7 sticky", {31'b0, sys_rst_o}, 32'h1);

        // R7 no reset with bit 1 clear; R9 masking
        cyc(1'b1, 1'b0, 12'h0, 32'h0, 1'b0);
        wr(A_KEY, KEY);
        wr(A_LOAD, 32'd1);
        wr(A_CTRL, 32'd1);
        ticks(4);
        peek("R7 irq pending", A_RAW, 32'h1);
        check("R7 no reset", {31'b0, sys_rst_o}, 32'h0);
        wr(A_CTRL, 32'd0);
        peek("R9 raw unmasked", A_RAW, 32'h1);
        peek("R9 masked off", A_MIS, 32'h0);
        check("R9 irq_o off", {31'b0, irq_o}, 32'h0);

        // R2 close, R3 clear ignored
        wr(A_KEY, 32'd1);
        peek("R2 closed", A_KEY, 32'h1);
        wr(A_CLR, 32'h0);
        peek("R3 clear ignored", A_RAW, 32'h1);
        wr(A_KEY, KEY);
        wr(A_CTRL, 32'd1);

        // R8 clear wins over a simultaneous expiry
        wr(A_LOAD, 32'd2);
        ticks(2);
        cyc(1'b0, 1'b1, A_CLR, 32'h0, 1'b1);
        peek("R8 clear beats expiry", A_RAW, 32'h0);
        peek("R8 clear reload", A_VALUE, 32'd2);

        check_model();

        // random mix against the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 70)      cyc(1'b0, 1'b0, 12'h0, 32'h0, 1'($urandom % 2));
            else if (r < 76) cyc(1'b0, 1'b1, A_LOAD, $urandom % 10, 1'($urandom % 2));
            else if (r < 83) cyc(1'b0, 1'b1, A_CTRL, $urandom, 1'($urandom % 2));
            else if (r < 90) cyc(1'b0, 1'b1, A_CLR, $urandom, 1'($urandom % 2));
            else if (r < 95) cyc(1'b0, 1'b1, A_KEY, KEY, 1'($urandom % 2));
            else if (r < 98) cyc(1'b0, 1'b1, A_KEY, $urandom, 1'($urandom % 2));
            else             cyc(1'b1, 1'b0, 12'h0, 32'h0, 1'b0);
            check_model();
            peek("R4 load model", A_LOAD, m_load);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule